// File: doc/BRIEF.md
# Serial Configuration Port for a Camera Front End

This block is the write-only control port of a camera analog front end. An external controller frames each write with an active-low enable. While the enable is low, the controller clocks in twelve serial bits. The first two bits choose one of four configuration registers, and the remaining ten carry the value. The registers hold:

- the converter clamp level;
- the front-end bandwidth code;
- the amplifier gain code;
- three pulse-polarity selects for the sampling, clamp and converter-clock paths.

The port has no readback path. Each register value appears directly on the block's outputs, where it drives the analog controls.

The three serial pins are asynchronous to the system clock, so they pass through synchronisers and edge detectors first. A frame takes effect only when the enable rises after exactly twelve serial clocks; a frame of any other length leaves every register unchanged. The block keeps a flag that marks the gain code as stale once the clamp code has been written. The flag clears when the gain code is written again. The block also carries the twelve-bit converter result to its output and forces that output to zero while standby is asserted.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, the clamp, cut-off and gain codes are 0, `sh_sample_low` is 0, `clamp_active_high` is 1, `conv_clk_rising` is 1, `gain_stale` is 0 and `conv_data_out` is 0.
- R2: While `sen_n` is low, a bit is taken from `sdata` on each rising edge of `sclk`. The first bit is address bit 1, the second is address bit 0, and the data follows from bit 9 (most significant) down to bit 0.
- R3: A register is written only on the rising edge of `sen_n`, and only if exactly 12 bits were clocked since `sen_n` fell. Frames of 0, 11 or 13 bits change nothing.
- R4: Address 0 (binary 00) loads all 10 data bits into `clamp_code`.
- R5: Address 1 (binary 01) loads data bits 3..0 into `cutoff_code`; data bits 9..4 are ignored.
- R6: Address 2 (binary 10) loads all 10 data bits into `gain_code`.
- R7: Address 3 (binary 11) loads the polarity selects from the data bits, and data bits 9..3 are ignored:
  - bit 0 goes to `sh_sample_low` (1 = sample on low level);
  - bit 1 goes to `clamp_active_high` (1 = clamp pulses active high);
  - bit 2 goes to `conv_clk_rising` (1 = rising edge).
- R8: `gain_stale` is set by a write to address 0 and cleared by a write to address 2. Writes to the other addresses leave it unchanged.
- R9: `conv_data_out` follows `conv_data_in` one clock later. It is 0 in the clock after any clock in which `standby` is high.
- R10: A register output changes only in the clock after a completed twelve-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Serial frame enable, active low, asynchronous |
| sclk | input | 1 | Serial bit clock, asynchronous |
| sdata | input | 1 | Serial data, asynchronous |
| standby | input | 1 | Forces the parallel data output to zero |
| conv_data_in | input | 12 | Converter result from the core |
| conv_data_out | output | 12 | Registered parallel data output |
| clamp_code | output | 10 | Converter clamp level code |
| cutoff_code | output | 4 | Front-end bandwidth code |
| gain_code | output | 10 | Amplifier gain code |
| sh_sample_low | output | 1 | Sample-and-hold pulses sample on low level |
| clamp_active_high | output | 1 | Clamp pulses active high |
| conv_clk_rising | output | 1 | Converter clock acts on its rising edge |
| gain_stale | output | 1 | Gain code must be rewritten after a clamp write |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a twelve-bit data path.

With these values, a serial half-period of four system clocks is slow enough for the synchroniser to settle. It is also fast enough that 11-, 12- and 13-bit frames run back to back within a few hundred cycles. The twelve-bit output width lets the standby test use an all-ones pattern and a mixed pattern at full width.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 10;
  localparam int CUT_W   = 4;
  localparam int EDGE_W  = 3;
  localparam int FRAME_W = ADDR_W + DATA_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CLAMP  = 2'b00,
    SEL_CUTOFF = 2'b01,
    SEL_GAIN   = 2'b10,
    SEL_EDGE   = 2'b11
  } cfg_sel_e;

  // bit2 rising clock, bit1 clamp active high, bit0 sample on low level
  localparam logic [EDGE_W-1:0] EDGE_RST = 3'b110;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign q    = stg_q[STAGES-1];
  assign rise = q & ~prev_q;
  assign fall = ~q & prev_q;
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_lvl,
  input  logic              sen_rise,
  input  logic              sclk_rise,
  input  logic              sdata_lvl,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               load_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [DATA_W-1:0]  data_d;
  logic               cap_en;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (sen_lvl) begin
      cnt_d = '0;
    end else if (sclk_rise) begin
      shift_d = {shift_q[FRAME_W-2:0], sdata_lvl};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
    cap_en = sen_rise && (cnt_q == CNT_FULL);
    load_d = cap_en;
    addr_d = shift_q[FRAME_W-1 -: ADDR_W];
    data_d = shift_q[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      load_o  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      load_o  <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (cap_en) begin
      addr_o <= addr_d;
      data_o <= data_d;
    end
  end

  assert_short_long_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_rise && cnt_q != CNT_FULL) |=> !load_o);
  assert_full_frame_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_rise && cnt_q == CNT_FULL) |=> load_o);
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] clamp_q,
  output logic [CUT_W-1:0]  cutoff_q,
  output logic [DATA_W-1:0] gain_q,
  output logic [EDGE_W-1:0] edge_q,
  output logic              stale_q
);
  logic [DATA_W-1:0] clamp_d, gain_d;
  logic [CUT_W-1:0]  cutoff_d;
  logic [EDGE_W-1:0] edge_d;
  logic              stale_d;
  cfg_sel_e          sel;

  always_comb begin
    sel      = cfg_sel_e'(addr_i);
    clamp_d  = clamp_q;
    cutoff_d = cutoff_q;
    gain_d   = gain_q;
    edge_d   = edge_q;
    stale_d  = stale_q;
    if (load_i) begin
      unique case (sel)
        SEL_CLAMP:  begin clamp_d = data_i; stale_d = 1'b1; end
        SEL_CUTOFF: cutoff_d = data_i[CUT_W-1:0];
        SEL_GAIN:   begin gain_d = data_i; stale_d = 1'b0; end
        SEL_EDGE:   edge_d = data_i[EDGE_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q  <= '0;
      cutoff_q <= '0;
      gain_q   <= '0;
      edge_q   <= EDGE_RST;
      stale_q  <= 1'b0;
    end else if (load_i) begin
      clamp_q  <= clamp_d;
      cutoff_q <= cutoff_d;
      gain_q   <= gain_d;
      edge_q   <= edge_d;
      stale_q  <= stale_d;
    end
  end

  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(clamp_q) && $stable(cutoff_q) && $stable(gain_q) && $stable(edge_q)));
  assert_stale_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && addr_i == SEL_CLAMP) |=> stale_q);
  assert_stale_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && addr_i == SEL_GAIN) |=> !stale_q);
  assert_gain_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && addr_i != SEL_GAIN) |=> $stable(gain_q));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DOUT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sen_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              standby,
  input  logic [DOUT_W-1:0] conv_data_in,
  output logic [DOUT_W-1:0] conv_data_out,
  output logic [DATA_W-1:0] clamp_code,
  output logic [CUT_W-1:0]  cutoff_code,
  output logic [DATA_W-1:0] gain_code,
  output logic              sh_sample_low,
  output logic              clamp_active_high,
  output logic              conv_clk_rising,
  output logic              gain_stale
);
  // pin order in the synchroniser: {sdata, sclk, sen_n}
  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic              load;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [EDGE_W-1:0] edge_sel;
  logic [DOUT_W-1:0] dout_d;

  cfg_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sdata, sclk, sen_n}),
    .q(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  cfg_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sen_lvl(pin_lvl[0]), .sen_rise(pin_rise[0]),
    .sclk_rise(pin_rise[1]), .sdata_lvl(pin_lvl[2]),
    .load_o(load), .addr_o(addr), .data_o(data)
  );

  cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(load), .addr_i(addr), .data_i(data),
    .clamp_q(clamp_code), .cutoff_q(cutoff_code), .gain_q(gain_code),
    .edge_q(edge_sel), .stale_q(gain_stale)
  );

  assign sh_sample_low     = edge_sel[0];
  assign clamp_active_high = edge_sel[1];
  assign conv_clk_rising   = edge_sel[2];

  always_comb dout_d = standby ? '0 : conv_data_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_data_out <= '0;
    else        conv_data_out <= dout_d;
  end

  assert_standby_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (conv_data_out == '0));
  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |=> (conv_data_out == $past(conv_data_in)));
  assert_no_load_enable_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_lvl[0] == 1'b0 && !pin_fall[0]) |=> !load);
endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen_n = 1'b1, sclk = 1'b0, sdata = 1'b0, standby = 1'b0;
  logic [11:0] conv_data_in = '0;
  logic [11:0] conv_data_out;
  logic [9:0]  clamp_code, gain_code;
  logic [3:0]  cutoff_code;
  logic sh_sample_low, clamp_active_high, conv_clk_rising, gain_stale;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdata(sdata),
    .standby(standby), .conv_data_in(conv_data_in), .conv_data_out(conv_data_out),
    .clamp_code(clamp_code), .cutoff_code(cutoff_code), .gain_code(gain_code),
    .sh_sample_low(sh_sample_low), .clamp_active_high(clamp_active_high),
    .conv_clk_rising(conv_clk_rising), .gain_stale(gain_stale)
  );

  // {tag[3:0], nbits[4:0], frame[11:0], clamp[9:0], cut[3:0], gain[9:0], edge{rise,clh,low}[2:0], stale}
  localparam int NV = 11;
  localparam logic [48:0] VEC [NV] = '{
    {4'd4,  5'd12, 12'h155, 10'h155, 4'h0, 10'h000, 3'b110, 1'b1},
    {4'd6,  5'd12, 12'hAAB, 10'h155, 4'h0, 10'h2AB, 3'b110, 1'b0},
    {4'd5,  5'd12, 12'h7FA, 10'h155, 4'hA, 10'h2AB, 3'b110, 1'b0},
    {4'd7,  5'd12, 12'hFF9, 10'h155, 4'hA, 10'h2AB, 3'b001, 1'b0},
    {4'd3,  5'd11, 12'h0F0, 10'h155, 4'hA, 10'h2AB, 3'b001, 1'b0},
    {4'd3,  5'd13, 12'h911, 10'h155, 4'hA, 10'h2AB, 3'b001, 1'b0},
    {4'd8,  5'd12, 12'h000, 10'h000, 4'hA, 10'h2AB, 3'b001, 1'b1},
    {4'd8,  5'd12, 12'h405, 10'h000, 4'h5, 10'h2AB, 3'b001, 1'b1},
    {4'd2,  5'd12, 12'hBFF, 10'h000, 4'h5, 10'h3FF, 3'b001, 1'b0},
    {4'd7,  5'd12, 12'hC06, 10'h000, 4'h5, 10'h3FF, 3'b110, 1'b0},
    {4'd3,  5'd0,  12'h000, 10'h000, 4'h5, 10'h3FF, 3'b110, 1'b0}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] regs_now();
    return {clamp_code, cutoff_code, gain_code,
            conv_clk_rising, clamp_active_high, sh_sample_low, gain_stale};
  endfunction

  task automatic send_frame(input int nbits, input logic [11:0] word);
    @(negedge clk);
    sen_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 12) ? word[11-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    sen_n = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1: reset state of every output
    check("R1", {9'd0, regs_now()}, {9'd0, 10'h000, 4'h0, 10'h000, 3'b110, 1'b0});
    check("R1", {25'd0, conv_data_out}, 37'd0);

    for (int v = 0; v < NV; v++) begin
      send_frame(int'(VEC[v][44:40]), VEC[v][39:28]);
      check(tag_name(VEC[v][48:45]), {9'd0, regs_now()}, {9'd0, VEC[v][27:0]});
    end

    // R9: pass-through then forced zero in standby
    conv_data_in = 12'hA5C;
    wait_clk(2);
    check("R9", {25'd0, conv_data_out}, {25'd0, 12'hA5C});
    standby = 1'b1;
    conv_data_in = 12'hFFF;
    wait_clk(2);
    check("R9", {25'd0, conv_data_out}, 37'd0);
    standby = 1'b0;
    wait_clk(2);
    check("R9", {25'd0, conv_data_out}, {25'd0, 12'hFFF});

    // R10: serial clocks with enable high do nothing
    for (int i = 0; i < 12; i++) begin
      sdata = 1'b1; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(10);
    check("R10", {9'd0, regs_now()}, {9'd0, VEC[NV-1][27:0]});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule